// File: doc/BRIEF.md
# Borrow Parallel Counter Column Array

This block reduces a weighted bit matrix to two binary rows in a single combinational pass. Every column `i` receives four lane bits of weight 2^i and one borrow bit of weight 2^(i+1). Each column cell tracks the lane count modulo four as a four-line one-hot residue code. The borrow bit is merged by rotating that code by two positions, so the low residue bit never changes. A separate quotient generator flags the case where the column value reaches four or more.

The addition is not done inside one column. The residue low bit, the residue high bit and the quotient bit of three neighbouring columns all carry the same weight. They are combined by a full adder whose pieces are spread over a chain of link slices. Each slice passes three link signals to the slice one weight below. The slices at both ends of the chain are fed constant zeros. The result is a sum row and a carry row, ready for a final carry-propagate adder. The column count is a parameter.

Top module: `bpcColumnArray`

## Requirements
- R1: For any input, the sum over j of sumOut[j]·2^j + carryOut[j]·2^(j+1) equals the sum over columns i of (number of set lanes in colBits[4i+3:4i])·2^i + borrowBits[i]·2^(i+1).
- R2: sumOut[0] equals the XOR of the four lanes colBits[3:0]. borrowBits[0] has no effect on it.
- R3: carryOut[0] is 0 for every input.
- R4: With all inputs zero, every bit of sumOut and carryOut is zero.
- R5: If column i has all four lanes set, its borrow set, and every other input is zero, then sumOut has exactly bits i+1 and i+2 set and carryOut is zero. This holds for the top column too, where the bits are NCOL and NCOL+1.
- R6: If the only set input is borrowBits[i], then sumOut has exactly bit i+1 set and carryOut is zero.
- R7: If the only set input is one lane of column i, then sumOut has exactly bit i set and carryOut is zero.
- R8: If the only set inputs are two lanes of column i, then sumOut has exactly bit i+1 set and carryOut is zero.
- R9: If the only set inputs are three lanes of column i plus borrowBits[i], then sumOut has exactly bits i and i+2 set and carryOut is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| colBits | input | 4*NCOL | Lane bits. Column i occupies bits [4i+3:4i], each of weight 2^i |
| borrowBits | input | NCOL | Borrow bit of column i, weight 2^(i+1) |
| sumOut | output | NCOL+2 | Sum row; bit j has weight 2^j |
| carryOut | output | NCOL+2 | Carry row; bit j has weight 2^(j+1) |

## Verification
The block holds no state, so a fault inside a cell appears at the ports in the same evaluation as the stimulus.

A residue code with a wrong line, or a borrow merge that rotates wrongly, shifts the value seen at weights 2^i and 2^(i+1) of that column. A wrong quotient shifts weight 2^(i+2). A broken link slice shows up as a wrong sum or carry bit two weights above its own column. In every case the weighted total of the two output rows disagrees with the input total.

The single-column patterns place one known residue and quotient value in each column in turn. A fault is therefore tied to an exact output bit, not only to a wrong total.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  localparam int LANES = 4;

  // Residue code: line k high means value k (mod 4).
  typedef logic [3:0] res1h_t;

  localparam res1h_t RES_ZERO = 4'b0001;

  // Advance a residue code by one (mod 4).
  function automatic res1h_t resStep1(input res1h_t r);
    return {r[2:0], r[3]};
  endfunction

  // Advance a residue code by two (mod 4): the borrow merge.
  function automatic res1h_t resStep2(input res1h_t r);
    return {r[1:0], r[3:2]};
  endfunction

  // Low residue bit: odd values are on lines 1 and 3.
  function automatic logic resLow(input res1h_t r);
    return r[1] | r[3];
  endfunction

  // High residue bit: values 2 and 3.
  function automatic logic resHigh(input res1h_t r);
    return r[2] | r[3];
  endfunction

endpackage

// File: rtl/bpcResidueEnc.sv
module bpcResidueEnc
  import bpc_pkg::*;
(
  input  logic [LANES-1:0] laneBits,
  input  logic             borrowBit,
  output res1h_t           rawCode,
  output res1h_t           mergedCode,
  output logic             s0Bit,
  output logic             s1Bit
);

  // Chain of one-hot rotators, one stage per lane.
  res1h_t stageCode [LANES+1];

  assign stageCode[0] = RES_ZERO;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign stageCode[k+1] = laneBits[k] ? resStep1(stageCode[k]) : stageCode[k];
  end

  assign rawCode = stageCode[LANES];

  // A weight-2 input moves the residue by two, so the odd/even line pair is kept.
  assign mergedCode = borrowBit ? resStep2(rawCode) : rawCode;

  assign s0Bit = resLow(mergedCode);
  assign s1Bit = resHigh(mergedCode);

endmodule

// File: rtl/bpcQuotientGen.sv
module bpcQuotientGen
  import bpc_pkg::*;
(
  input  logic [LANES-1:0] laneBits,
  input  logic             borrowBit,
  output logic             quotBit
);

  logic allSet;
  logic twoOrMore;

  assign allSet    = &laneBits;
  assign twoOrMore = (laneBits[0] & (laneBits[1] | laneBits[2] | laneBits[3]))
                   | (laneBits[1] & (laneBits[2] | laneBits[3]))
                   | (laneBits[2] & laneBits[3]);

  // Column value reaches four: four lanes, or borrow plus at least two lanes.
  assign quotBit = allSet | (borrowBit & twoOrMore);

endmodule

// File: rtl/bpcLinkSlice.sv
module bpcLinkSlice (
  input  logic s0Loc,
  input  logic s1Loc,
  input  logic qLoc,
  input  logic xIn,
  input  logic yIn,
  input  logic zIn,
  output logic xOut,
  output logic yOut,
  output logic zOut,
  output logic sumBit,
  output logic carryBit
);

  // Downward links: the low residue bit leaves, is paired with the next
  // high residue bit, then meets the quotient one column further down.
  assign xOut = s0Loc;
  assign yOut = xIn ^ s1Loc;
  assign zOut = xIn;

  // Three-operand sum and majority carry.
  assign sumBit   = yIn ^ qLoc;
  assign carryBit = yIn ? qLoc : zIn;

endmodule

// File: rtl/bpcColumnArray.sv
module bpcColumnArray
  import bpc_pkg::*;
#(
  parameter int NCOL = 16
) (
  input  logic [NCOL*LANES-1:0] colBits,
  input  logic [NCOL-1:0]       borrowBits,
  output logic [NCOL+1:0]       sumOut,
  output logic [NCOL+1:0]       carryOut
);

  localparam int NSLICE = NCOL + 2;

  logic [NCOL-1:0][3:0] rawBus;
  logic [NCOL-1:0][3:0] mergedBus;
  logic [NCOL-1:0]      s0Vec;
  logic [NCOL-1:0]      s1Vec;
  logic [NCOL-1:0]      qVec;

  // Column cells.
  for (genvar c = 0; c < NCOL; c++) begin : g_cell
    res1h_t rawC;
    res1h_t mergedC;

    bpcResidueEnc uEnc (
      .laneBits  (colBits[c*LANES +: LANES]),
      .borrowBit (borrowBits[c]),
      .rawCode   (rawC),
      .mergedCode(mergedC),
      .s0Bit     (s0Vec[c]),
      .s1Bit     (s1Vec[c])
    );

    bpcQuotientGen uQuot (
      .laneBits (colBits[c*LANES +: LANES]),
      .borrowBit(borrowBits[c]),
      .quotBit  (qVec[c])
    );

    assign rawBus[c]    = rawC;
    assign mergedBus[c] = mergedC;
  end

  // Link chain. Index t holds the links driven by slice t; slice t reads t+1.
  // Slice t carries column t-2. Zeros enter the chain at the top.
  logic [NSLICE:1] xChain;
  logic [NSLICE:1] yChain;
  logic [NSLICE:1] zChain;
  logic [2:0]      unusedLinks;

  assign xChain[NSLICE] = 1'b0;
  assign yChain[NSLICE] = 1'b0;
  assign zChain[NSLICE] = 1'b0;

  for (genvar t = 0; t < NSLICE; t++) begin : g_slice
    logic s0L, s1L, qL;
    logic xO, yO, zO;

    if (t >= 2) begin : g_col
      assign s0L = s0Vec[t-2];
      assign s1L = s1Vec[t-2];
      assign qL  = qVec[t-2];
    end else begin : g_pad
      assign s0L = 1'b0;
      assign s1L = 1'b0;
      assign qL  = 1'b0;
    end

    bpcLinkSlice uLink (
      .s0Loc   (s0L),
      .s1Loc   (s1L),
      .qLoc    (qL),
      .xIn     (xChain[t+1]),
      .yIn     (yChain[t+1]),
      .zIn     (zChain[t+1]),
      .xOut    (xO),
      .yOut    (yO),
      .zOut    (zO),
      .sumBit  (sumOut[t]),
      .carryBit(carryOut[t])
    );

    if (t >= 1) begin : g_fwd
      assign xChain[t] = xO;
      assign yChain[t] = yO;
      assign zChain[t] = zO;
    end else begin : g_end
      assign unusedLinks = {xO, yO, zO};
    end
  end

endmodule

// File: rtl/bpcColumnArray_chk.sv
module bpcColumnArray_chk
  import bpc_pkg::*;
#(
  parameter int NCOL = 16
) (
  input logic [NCOL*LANES-1:0] colBits,
  input logic [NCOL-1:0]       borrowBits,
  input logic [NCOL+1:0]       sumOut,
  input logic [NCOL+1:0]       carryOut,
  input logic [NCOL-1:0][3:0]  rawBus,
  input logic [NCOL-1:0][3:0]  mergedBus,
  input logic [NCOL-1:0]       s0Vec,
  input logic [NCOL-1:0]       s1Vec,
  input logic [NCOL-1:0]       qVec
);

  localparam int TW = NCOL + 4;

  logic [TW-1:0] inTotal;
  logic [TW-1:0] outTotal;

  always_comb begin
    inTotal = '0;
    for (int c = 0; c < NCOL; c++) begin
      inTotal = inTotal + (TW'($countones(colBits[c*LANES +: LANES])) << c);
      inTotal = inTotal + (TW'(borrowBits[c]) << (c + 1));
    end
  end

  always_comb begin
    outTotal = '0;
    for (int j = 0; j < NCOL + 2; j++) begin
      outTotal = outTotal + (TW'(sumOut[j]) << j) + (TW'(carryOut[j]) << (j + 1));
    end
  end

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      // R1: residue buses carry exactly one hot line
      a_r1_onehot_raw: assert ($countones(rawBus[c]) == 1)
        else $error("raw residue not one-hot in column %0d", c);
      a_r1_onehot_merged: assert ($countones(mergedBus[c]) == 1)
        else $error("merged residue not one-hot in column %0d", c);
      // R1: per-cell balance between encoder, merge and quotient generator
      a_r1_cell_identity: assert (int'({qVec[c], s1Vec[c], s0Vec[c]}) ==
                                  $countones(colBits[c*LANES +: LANES]) + 2 * int'(borrowBits[c]))
        else $error("cell balance broken in column %0d", c);
    end
    a_r1_total: assert (outTotal == inTotal)
      else $error("weighted total mismatch");
    a_r2_low_parity: assert (sumOut[0] == ^colBits[LANES-1:0])
      else $error("sumOut[0] differs from column-0 parity");
    a_r3_no_low_carry: assert (carryOut[0] == 1'b0)
      else $error("carryOut[0] set");
  end

endmodule

bind bpcColumnArray bpcColumnArray_chk #(.NCOL(NCOL)) uChk (
  .colBits   (colBits),
  .borrowBits(borrowBits),
  .sumOut    (sumOut),
  .carryOut  (carryOut),
  .rawBus    (rawBus),
  .mergedBus (mergedBus),
  .s0Vec     (s0Vec),
  .s1Vec     (s1Vec),
  .qVec      (qVec)
);

// File: tb/bpcColumnArray_test.sv
module bpcColumnArray_test;

  localparam int NC = 8;
  localparam int TW = NC + 4;
  localparam int OW = NC + 2;

  typedef struct {
    string         req;
    logic [TW-1:0] expTotal;
    logic [OW-1:0] expSum;
    logic [OW-1:0] sumMask;
    logic [OW-1:0] expCarry;
    logic [OW-1:0] carryMask;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC*4-1:0] colBits = '0;
  logic [NC-1:0]   borrowBits = '0;
  logic [OW-1:0]   sumOut;
  logic [OW-1:0]   carryOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  item_t pending[$];

  always #2 clk = ~clk;  // 250 MHz

  bpcColumnArray #(.NCOL(NC)) uut (
    .colBits   (colBits),
    .borrowBits(borrowBits),
    .sumOut    (sumOut),
    .carryOut  (carryOut)
  );

  function automatic logic [TW-1:0] refTotal(input logic [NC*4-1:0] cb, input logic [NC-1:0] bb);
    logic [TW-1:0] acc = '0;
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 4; k++) acc = acc + (TW'(cb[c*4+k]) << c);
      acc = acc + (TW'(bb[c]) << (c + 1));
    end
    return acc;
  endfunction

  task automatic sendVec(input logic [NC*4-1:0] cb, input logic [NC-1:0] bb, input string req,
                         input logic [OW-1:0] es, input logic [OW-1:0] sm,
                         input logic [OW-1:0] ec, input logic [OW-1:0] cm);
    item_t it;
    @(posedge clk);
    colBits    = cb;
    borrowBits = bb;
    it.req = req;
    it.expTotal = refTotal(cb, bb);
    it.expSum = es;
    it.sumMask = sm;
    it.expCarry = ec;
    it.carryMask = cm;
    pending.push_back(it);
  endtask

  // Monitor: compares one item per cycle, half a period after it is driven.
  always @(negedge clk) begin
    if (pending.size() > 0) begin
      item_t it;
      logic [TW-1:0] got;
      it = pending.pop_front();
      got = '0;
      for (int j = 0; j < OW; j++)
        got = got + (TW'(sumOut[j]) << j) + (TW'(carryOut[j]) << (j + 1));
      checks++;
      if (got !== it.expTotal) begin
        errors++;
        $display("FAIL R1 weighted total: got %0d expected %0d", got, it.expTotal);
      end
      if ((it.sumMask | it.carryMask) != '0) begin
        checks++;
        if (((sumOut & it.sumMask) !== (it.expSum & it.sumMask)) ||
            ((carryOut & it.carryMask) !== (it.expCarry & it.carryMask))) begin
          errors++;
          $display("FAIL %s: sum %b carry %b expected sum %b carry %b (masks %b %b)",
                   it.req, sumOut, carryOut, it.expSum, it.expCarry, it.sumMask, it.carryMask);
        end
      end
    end
  end

  initial begin
    logic [OW-1:0] full;
    logic [NC*4-1:0] cb;
    logic [NC-1:0] bb;
    full = '1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R4: reset-like idle state, all zero
    sendVec('0, '0, "R4", '0, full, '0, full);

    for (int i = 0; i < NC; i++) begin
      // R6: borrow alone
      sendVec('0, NC'(1) << i, "R6", OW'(1) << (i + 1), full, '0, full);
      // R7: single lane, lane chosen by column
      cb = '0; cb[i*4 + (i % 4)] = 1'b1;
      sendVec(cb, '0, "R7", OW'(1) << i, full, '0, full);
      // R8: two lanes
      cb = '0; cb[i*4] = 1'b1; cb[i*4+2] = 1'b1;
      sendVec(cb, '0, "R8", OW'(1) << (i + 1), full, '0, full);
      // R9: three lanes plus borrow
      cb = '0; cb[i*4] = 1'b1; cb[i*4+1] = 1'b1; cb[i*4+3] = 1'b1;
      sendVec(cb, NC'(1) << i, "R9", (OW'(1) << i) | (OW'(1) << (i + 2)), full, '0, full);
      // R5: full column with borrow, top column included
      cb = '0; cb[i*4 +: 4] = 4'hF;
      sendVec(cb, NC'(1) << i, "R5", OW'(3) << (i + 1), full, '0, full);
    end

    // R2, R3: every column-0 pattern with its borrow, other columns random
    for (int v = 0; v < 32; v++) begin
      cb = $urandom;
      cb[3:0] = v[3:0];
      bb = NC'($urandom);
      bb[0] = v[4];
      sendVec(cb, bb, "R2 R3", OW'(^v[3:0]), OW'(1), '0, OW'(1));
    end

    // R1: all-ones corner and random patterns
    sendVec('1, '1, "R1", '0, '0, '0, '0);
    for (int n = 0; n < 3000; n++) begin
      sendVec(NC*4'($urandom), NC'($urandom), "R1", '0, '0, '0, '0);
    end

    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule